// File: doc/BRIEF.md
# Decoupled Receive Buffer Ring Manager

This block manages receive-side buffers for a multi-core network interface. Free host-memory buffers and queued received packets live in two separate sets of rings. Each core owns one allocation ring of free buffer addresses and one reception ring of completed packets. The two ring depths are independent parameters, so the pool of buffers can stay small while each core's packet queue stays deep.

A packet request carries a flow hash and a length. The low hash bits select the destination core. The block first checks that core's reception ring. If that ring is full, the packet is dropped before any buffer is touched. Otherwise the block takes the oldest address from the core's own allocation ring. If that ring is empty, it scans the other cores' allocation rings round-robin, starting with the core after the destination. When every pool is empty, the packet is dropped and a no-buffer counter increments.

With a buffer in hand, the block issues a one-cycle DMA write command. It then waits for the DMA-done strobe and posts address and length into the destination core's reception ring. Software on each core pops its own reception ring and returns freed buffers to its own allocation ring. Returns need no arbitration.

The controller has three states. `S_IDLE` accepts a request and decides its outcome. A drop stays in `S_IDLE`, and a taken buffer moves to `S_ISSUE`. `S_ISSUE` presents the DMA command for one cycle and moves unconditionally to `S_WAIT`. `S_WAIT` stays until `dma_done`, posts the entry and returns to `S_IDLE`.

Top module: `rxr_ring_mgr`

## Requirements
- R1: After reset `pkt_ready` is 1, `dma_cmd_valid` is 0, every `rx_empty` bit is 1, every `ret_full` bit is 0 and `nobuf_count` is 0.
- R2: The destination core is `pkt_hash[CW-1:0]`, where CW = log2(NCORE). `dma_core` carries that index, and the posted entry goes to that core's reception ring.
- R3: When the destination core's allocation ring is not empty, the buffer taken is that ring's oldest returned address.
- R4: When the destination's allocation ring is empty, the buffer comes from the first non-empty ring in the order dest+1, dest+2, ... modulo NCORE. The oldest address of that ring is taken.
- R5: When the reception ring has room but all allocation rings are empty, `drop_nobuf` is 1 for the one cycle after acceptance and `nobuf_count` rises by one. No DMA command is issued.
- R6: When the destination's reception ring holds RR_DEPTH entries, `drop_full` is 1 for the one cycle after acceptance. No DMA command is issued, and no allocation ring loses an entry.
- R7: In the cycle after acceptance, `dma_cmd_valid` is 1 for exactly one cycle, carrying the buffer address, length and core. `pkt_ready` stays 0 from then until the post.
- R8: `dma_done` in `S_WAIT` posts {length, address} to the reception ring. The ring is non-empty and `pkt_ready` is 1 in the next cycle. `dma_done` in `S_IDLE` has no effect.
- R9: `rx_addr`/`rx_len` slice k shows the oldest entry of core k's reception ring. `rx_pop[k]` removes it, and a pop on an empty ring is ignored.
- R10: `ret_valid[k]` appends `ret_addr` slice k to core k's allocation ring when `ret_full[k]` is 0. `ret_full[k]` is 1 after AR_DEPTH entries, and a return while full is ignored.
- R11: A push and a pop on the same ring in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet request present |
| pkt_ready | output | 1 | Request accepted this cycle when high |
| pkt_hash | input | HASH_W | Flow hash of the packet |
| pkt_len | input | LEN_W | Packet length in bytes |
| dma_cmd_valid | output | 1 | DMA write command strobe |
| dma_addr | output | ADDR_W | Buffer address for the DMA write |
| dma_len | output | LEN_W | Length for the DMA write |
| dma_core | output | CW | Destination core of the DMA write |
| dma_done | input | 1 | DMA write completion strobe |
| drop_full | output | 1 | Packet dropped, reception ring full |
| drop_nobuf | output | 1 | Packet dropped, no free buffer |
| nobuf_count | output | CNT_W | Count of no-buffer drops |
| rx_pop | input | NCORE | Per-core reception ring pop |
| rx_empty | output | NCORE | Per-core reception ring empty |
| rx_addr | output | NCORE*ADDR_W | Per-core oldest reception entry address |
| rx_len | output | NCORE*LEN_W | Per-core oldest reception entry length |
| ret_valid | input | NCORE | Per-core buffer return strobe |
| ret_addr | input | NCORE*ADDR_W | Per-core returned buffer address |
| ret_full | output | NCORE | Per-core allocation ring full |

## Verification
Two pairs of operations can hit the same ring in one cycle. In the first, a buffer is taken for a packet while software returns a buffer to the same core's allocation ring. In the second, a completed packet is posted while software pops the same core's reception ring. The bench drives each pair on the same clock edge on purpose. It then judges the result from the next addresses handed out and from the reception ring's head. If either operation is lost, a later address or the head value comes out wrong.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT
    } mgr_state_e;
endpackage

// File: rtl/rxr_ring.sv
module rxr_ring #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW:0]       head;
    logic [AW:0]       tail;
    logic              push_ok;
    logic              pop_ok;
    logic [AW:0]       occ;

    // wrap bit separates full from empty
    assign empty     = (head == tail);
    assign full      = (head[AW] != tail[AW]) && (head[AW-1:0] == tail[AW-1:0]);
    assign push_ok   = push && !full;
    assign pop_ok    = pop && !empty;
    assign head_data = mem[head[AW-1:0]];
    assign occ       = tail - head;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
        end else begin
            if (push_ok) tail <= tail + 1'b1;
            if (pop_ok)  head <= head + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[tail[AW-1:0]] <= push_data;
    end

    // R10: occupancy never exceeds the ring depth
    always @(posedge clk) begin
        if (rst_n) begin
            p_no_overflow_r10: assert (int'(occ) <= DEPTH)
                else $error("ring occupancy beyond depth");
        end
    end

    // R9: popping an empty ring leaves the read pointer alone
    p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> $stable(head));
endmodule

// File: rtl/rxr_fallback_pick.sv
module rxr_fallback_pick #(
    parameter int NCORE = 4,
    parameter int CW    = $clog2(NCORE)
) (
    input  logic [NCORE-1:0] avail,
    input  logic [CW-1:0]    start,
    output logic             found,
    output logic [CW-1:0]    idx
);
    // scan from the farthest offset down so the nearest one wins
    always_comb begin
        found = 1'b0;
        idx   = start;
        for (int k = NCORE - 1; k >= 1; k--) begin
            if (avail[(int'(start) + k) % NCORE]) begin
                found = 1'b1;
                idx   = CW'((int'(start) + k) % NCORE);
            end
        end
    end

    // R4: a pick is always a non-empty pool other than the destination
    always_comb begin
        if (found) begin
            p_pick_valid_r4: assert (avail[idx] && idx != start)
                else $error("fallback picked an unusable pool");
        end
    end
endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr
    import rxr_pkg::*;
#(
    parameter int NCORE    = 4,
    parameter int AR_DEPTH = 8,
    parameter int RR_DEPTH = 4,
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 14,
    parameter int HASH_W   = 32,
    parameter int CNT_W    = 16,
    parameter int CW       = $clog2(NCORE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pkt_valid,
    output logic                    pkt_ready,
    input  logic [HASH_W-1:0]       pkt_hash,
    input  logic [LEN_W-1:0]        pkt_len,
    output logic                    dma_cmd_valid,
    output logic [ADDR_W-1:0]       dma_addr,
    output logic [LEN_W-1:0]        dma_len,
    output logic [CW-1:0]           dma_core,
    input  logic                    dma_done,
    output logic                    drop_full,
    output logic                    drop_nobuf,
    output logic [CNT_W-1:0]        nobuf_count,
    input  logic [NCORE-1:0]        rx_pop,
    output logic [NCORE-1:0]        rx_empty,
    output logic [NCORE*ADDR_W-1:0] rx_addr,
    output logic [NCORE*LEN_W-1:0]  rx_len,
    input  logic [NCORE-1:0]        ret_valid,
    input  logic [NCORE*ADDR_W-1:0] ret_addr,
    output logic [NCORE-1:0]        ret_full
);
    localparam int ENT_W = ADDR_W + LEN_W;

    mgr_state_e state, nxt;

    logic [NCORE-1:0]  a_empty, a_pop, r_full, r_push;
    logic [ADDR_W-1:0] a_head [NCORE];
    logic [ENT_W-1:0]  r_head [NCORE];

    logic [ADDR_W-1:0] lat_addr;
    logic [LEN_W-1:0]  lat_len;
    logic [CW-1:0]     lat_core;
    logic              drop_full_q, drop_nobuf_q;
    logic [CNT_W-1:0]  nobuf_q;

    logic [CW-1:0] dest, src, pick_idx;
    logic          pick_found, acc, own_ok, full_drop, take, nobuf;
    logic          unused_hash;

    assign dest        = pkt_hash[CW-1:0];
    assign unused_hash = ^pkt_hash[HASH_W-1:CW];

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        rxr_ring #(.DEPTH(AR_DEPTH), .DATA_W(ADDR_W)) u_alloc (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (ret_valid[g]),
            .push_data (ret_addr[g*ADDR_W +: ADDR_W]),
            .pop       (a_pop[g]),
            .head_data (a_head[g]),
            .empty     (a_empty[g]),
            .full      (ret_full[g])
        );
        rxr_ring #(.DEPTH(RR_DEPTH), .DATA_W(ENT_W)) u_recv (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (r_push[g]),
            .push_data ({lat_len, lat_addr}),
            .pop       (rx_pop[g]),
            .head_data (r_head[g]),
            .empty     (rx_empty[g]),
            .full      (r_full[g])
        );
        assign rx_addr[g*ADDR_W +: ADDR_W] = r_head[g][ADDR_W-1:0];
        assign rx_len[g*LEN_W +: LEN_W]    = r_head[g][ENT_W-1:ADDR_W];
    end

    rxr_fallback_pick #(.NCORE(NCORE), .CW(CW)) u_pick (
        .avail (~a_empty),
        .start (dest),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // admission decision, reception room checked before any buffer is taken
    assign acc       = (state == S_IDLE) && pkt_valid;
    assign own_ok    = !a_empty[dest];
    assign src       = own_ok ? dest : pick_idx;
    assign full_drop = acc && r_full[dest];
    assign take      = acc && !r_full[dest] && (own_ok || pick_found);
    assign nobuf     = acc && !r_full[dest] && !own_ok && !pick_found;

    // next-state process
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (take) nxt = S_ISSUE;
            S_ISSUE: nxt = S_WAIT;
            S_WAIT:  if (dma_done) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // output process
    always_comb begin
        pkt_ready     = (state == S_IDLE);
        dma_cmd_valid = (state == S_ISSUE);
        a_pop         = take ? (NCORE'(1) << src) : '0;
        r_push        = (state == S_WAIT && dma_done) ? (NCORE'(1) << lat_core) : '0;
    end

    // latched command and drop reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr     <= '0;
            lat_len      <= '0;
            lat_core     <= '0;
            drop_full_q  <= 1'b0;
            drop_nobuf_q <= 1'b0;
            nobuf_q      <= '0;
        end else begin
            if (take) begin
                lat_addr <= a_head[src];
                lat_len  <= pkt_len;
                lat_core <= dest;
            end
            drop_full_q  <= full_drop;
            drop_nobuf_q <= nobuf;
            if (nobuf) nobuf_q <= nobuf_q + 1'b1;
        end
    end

    assign dma_addr    = lat_addr;
    assign dma_len     = lat_len;
    assign dma_core    = lat_core;
    assign drop_full   = drop_full_q;
    assign drop_nobuf  = drop_nobuf_q;
    assign nobuf_count = nobuf_q;

    // R7: command lasts one cycle and the input side is closed meanwhile
    p_cmd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cmd_valid |=> !dma_cmd_valid);
    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cmd_valid |-> !pkt_ready);
    // R5: every no-buffer drop is counted exactly once
    p_nobuf_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_nobuf |-> nobuf_count == $past(nobuf_count) + 1'b1);
    // R6: a full reception ring drains no pool
    p_full_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && r_full[dest]) |-> (a_pop == '0));
    // R8: a completion posts and reopens the input
    p_post_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && dma_done) |=> (pkt_ready && !rx_empty[lat_core]));
endmodule

// File: tb/rxr_ring_mgr_bench.sv
module rxr_ring_mgr_bench;
    localparam int NC = 4;
    localparam int AW = 32;
    localparam int LW = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pkt_valid = 1'b0;
    logic            pkt_ready;
    logic [31:0]     pkt_hash = '0;
    logic [LW-1:0]   pkt_len = '0;
    logic            dma_cmd_valid;
    logic [AW-1:0]   dma_addr;
    logic [LW-1:0]   dma_len;
    logic [1:0]      dma_core;
    logic            dma_done = 1'b0;
    logic            drop_full, drop_nobuf;
    logic [15:0]     nobuf_count;
    logic [NC-1:0]   rx_pop = '0;
    logic [NC-1:0]   rx_empty;
    logic [NC*AW-1:0] rx_addr;
    logic [NC*LW-1:0] rx_len;
    logic [NC-1:0]   ret_valid = '0;
    logic [NC*AW-1:0] ret_addr = '0;
    logic [NC-1:0]   ret_full;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [1:0]    core;
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    rxr_ring_mgr u_rxr_ring_mgr (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_hash(pkt_hash), .pkt_len(pkt_len),
        .dma_cmd_valid(dma_cmd_valid), .dma_addr(dma_addr),
        .dma_len(dma_len), .dma_core(dma_core), .dma_done(dma_done),
        .drop_full(drop_full), .drop_nobuf(drop_nobuf),
        .nobuf_count(nobuf_count),
        .rx_pop(rx_pop), .rx_empty(rx_empty),
        .rx_addr(rx_addr), .rx_len(rx_len),
        .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_full(ret_full)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every DMA command is compared with the scoreboard
    always @(negedge clk) begin
        if (rst_n && dma_cmd_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7 unexpected DMA command", dma_addr, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(dma_addr == e.addr, "R3/R4 dma address", dma_addr, e.addr);
                check(dma_core == e.core, "R2 dma core", dma_core, e.core);
                check(dma_len == e.len, "R7 dma length", dma_len, e.len);
            end
        end
    end

    task automatic ret_buf(input int core, input logic [AW-1:0] a);
        ret_valid[core] = 1'b1;
        ret_addr[core*AW +: AW] = a;
        @(negedge clk);
        ret_valid = '0;
    endtask

    // kind: 0 buffer taken, 1 reception-full drop, 2 no-buffer drop
    task automatic send_pkt(input logic [31:0] h, input logic [LW-1:0] l,
                            input int kind, input logic [AW-1:0] ea,
                            input logic [NC-1:0] ret_mask, input logic [AW-1:0] ra);
        if (kind == 0) sb_q.push_back('{core: h[1:0], addr: ea, len: l});
        check(pkt_ready == 1'b1, "R8 ready before request", pkt_ready, 1);
        pkt_valid = 1'b1;
        pkt_hash  = h;
        pkt_len   = l;
        for (int k = 0; k < NC; k++) begin
            if (ret_mask[k]) begin
                ret_valid[k] = 1'b1;
                ret_addr[k*AW +: AW] = ra;
            end
        end
        @(negedge clk);
        pkt_valid = 1'b0;
        ret_valid = '0;
        check(drop_full == (kind == 1), "R6 drop_full flag", drop_full, kind == 1);
        check(drop_nobuf == (kind == 2), "R5 drop_nobuf flag", drop_nobuf, kind == 2);
        check(dma_cmd_valid == (kind == 0), "R7 command strobe", dma_cmd_valid, kind == 0);
        check(pkt_ready == (kind != 0), "R7 ready while busy", pkt_ready, kind != 0);
    endtask

    task automatic finish_dma(input logic [NC-1:0] pop_mask);
        @(negedge clk);
        dma_done = 1'b1;
        rx_pop   = pop_mask;
        @(negedge clk);
        dma_done = 1'b0;
        rx_pop   = '0;
        check(pkt_ready == 1'b1, "R8 ready after post", pkt_ready, 1);
    endtask

    task automatic pop_rx(input int core);
        rx_pop[core] = 1'b1;
        @(negedge clk);
        rx_pop = '0;
    endtask

    initial begin
        logic [NC-1:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pkt_ready == 1'b1, "R1 ready", pkt_ready, 1);
        check(dma_cmd_valid == 1'b0, "R1 no command", dma_cmd_valid, 0);
        check(rx_empty == 4'hF, "R1 rx empty", rx_empty, 4'hF);
        check(ret_full == 4'h0, "R1 ret_full", ret_full, 0);
        check(nobuf_count == 0, "R1 counter", nobuf_count, 0);

        // R10 returns into pools 0 and 2
        ret_buf(0, 32'h1000);
        ret_buf(0, 32'h1040);
        ret_buf(2, 32'h3000);

        // R2 R3 own pool, then R8 post contents
        send_pkt(32'hABCD_0004, 14'd100, 0, 32'h1000, '0, '0);
        finish_dma('0);
        check(rx_empty[0] == 1'b0, "R8 posted core0", rx_empty[0], 0);
        check(rx_addr[0 +: AW] == 32'h1000, "R8 posted address", rx_addr[0 +: AW], 32'h1000);
        check(rx_len[0 +: LW] == 14'd100, "R8 posted length", rx_len[0 +: LW], 100);

        // R4 fallback from core1 reaches core2
        send_pkt(32'h0000_0005, 14'd64, 0, 32'h3000, '0, '0);
        finish_dma('0);
        check(rx_addr[1*AW +: AW] == 32'h3000, "R2 posted to core1", rx_addr[1*AW +: AW], 32'h3000);
        // R4 fallback from core3 wraps to core0
        send_pkt(32'h0000_0007, 14'd65, 0, 32'h1040, '0, '0);
        finish_dma('0);

        // R5 all pools empty
        send_pkt(32'h0000_0006, 14'd10, 2, '0, '0, '0);
        check(nobuf_count == 16'd1, "R5 counter", nobuf_count, 1);

        // R6 fill core1 reception ring
        for (int i = 0; i < 4; i++) ret_buf(1, 32'h2000 + 32'(i) * 32'h40);
        for (int i = 0; i < 3; i++) begin
            send_pkt(32'h0000_0001, 14'd200 + 14'(i), 0, 32'h2000 + 32'(i) * 32'h40, '0, '0);
            finish_dma('0);
        end
        send_pkt(32'h0000_0001, 14'd300, 1, '0, '0, '0);
        // R9 head order and pop
        check(rx_addr[1*AW +: AW] == 32'h3000, "R9 oldest entry", rx_addr[1*AW +: AW], 32'h3000);
        pop_rx(1);
        check(rx_addr[1*AW +: AW] == 32'h2000, "R9 after pop", rx_addr[1*AW +: AW], 32'h2000);
        // R6 no leak: next packet gets the buffer left behind
        send_pkt(32'h0000_0001, 14'd301, 0, 32'h20C0, '0, '0);
        finish_dma('0);

        // R10 fill core3 pool, extra return ignored
        for (int i = 0; i < 8; i++) ret_buf(3, 32'h4000 + 32'(i) * 32'h40);
        check(ret_full[3] == 1'b1, "R10 pool full", ret_full[3], 1);
        ret_buf(3, 32'hDEAD);
        for (int i = 0; i < 8; i++) begin
            send_pkt(32'h0000_0003, 14'd400, 0, 32'h4000 + 32'(i) * 32'h40, '0, '0);
            finish_dma('0);
            pop_rx(3);
        end
        send_pkt(32'h0000_0003, 14'd400, 2, '0, '0, '0);
        check(nobuf_count == 16'd2, "R10 ignored return left pools empty", nobuf_count, 2);

        // R11 return and allocation on pool 0 in the same cycle
        ret_buf(0, 32'h5000);
        send_pkt(32'h0000_0000, 14'd50, 0, 32'h5000, 4'b0001, 32'h5040);
        // R11 post and pop on core0 reception ring in the same cycle
        finish_dma(4'b0001);
        check(rx_empty[0] == 1'b0, "R11 ring kept new entry", rx_empty[0], 0);
        check(rx_addr[0 +: AW] == 32'h5000, "R11 head after push+pop", rx_addr[0 +: AW], 32'h5000);
        send_pkt(32'h0000_0000, 14'd51, 0, 32'h5040, '0, '0);
        finish_dma('0);

        // R8 dma_done while idle has no effect
        snap = rx_empty;
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
        @(negedge clk);
        check(rx_empty == snap, "R8 idle done ignored", rx_empty, snap);
        check(pkt_ready == 1'b1, "R8 idle done ready", pkt_ready, 1);

        // R9 pop on empty ring ignored
        pop_rx(2);
        check(rx_empty[2] == 1'b1, "R9 empty stays empty", rx_empty[2], 1);
        ret_buf(2, 32'h6000);
        send_pkt(32'h0000_0002, 14'd77, 0, 32'h6000, '0, '0);
        finish_dma('0);
        check(rx_addr[2*AW +: AW] == 32'h6000, "R9 ring intact after empty pop", rx_addr[2*AW +: AW], 32'h6000);
        check(rx_len[2*LW +: LW] == 14'd77, "R9 length intact", rx_len[2*LW +: LW], 77);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R7 all commands seen", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule